// File: doc/BRIEF.md
# Flag-Setting Add/Subtract/Compare Unit

This block is the arithmetic core of an integer execution stage. It adds or subtracts two operands, forwards an operand unchanged for a move, or runs a compare that exists only for its effect on the condition flags. Next to the datapath it holds a four-bit status register of negative, zero, carry and overflow flags. Later conditional logic reads these flags to decide whether a branch or a predicated operation proceeds.

The result and the register write-enable are combinational from the inputs. The flags are registered and change on the rising clock edge. An add, subtract or move updates them only when the set-flags request is high. A compare or compare-negated always updates them, and it never asserts the write-enable. On subtraction the carry flag is the inverse of the borrow, so it reads 1 when the first operand is at least the second when both are taken as unsigned numbers.

Top module: `as_flag_alu`

## Requirements
- R1: With `op_i` = 0 (add), `result_o` = `a_i + b_i` modulo 2^WIDTH. When the flags update, C (bit 1 of `flags_o`) is the carry out of the top bit.
- R2: With `op_i` = 1 (subtract), `result_o` = `a_i - b_i`, computed as `a_i + ~b_i + 1`. When the flags update, C is 1 when no borrow occurs (unsigned `a_i >= b_i`) and 0 otherwise.
- R3: When the flags update from an arithmetic result, N (bit 3) equals the top bit of that result, and Z (bit 2) is 1 exactly when all result bits are zero.
- R4: When the flags update from an arithmetic result, V (bit 0) is 1 exactly when the result overflows as a two's-complement number: both effective operands have the same sign and the result's sign differs from it.
- R5: For add, subtract or move with `set_flags_i` = 0, `flags_o` keeps its previous value across the clock edge.
- R6: With `op_i` = 2 (compare, `a_i - b_i`) or 3 (compare-negated, `a_i + b_i`), all four flags update on the next edge whatever `set_flags_i` is, and `wr_en_o` is 0.
- R7: With `op_i` = 4 (move), `result_o` = `b_i`. With `set_flags_i` = 1, N and Z follow `b_i` and C and V keep their previous values.
- R8: Op codes 5 to 7 are reserved. They give `result_o` = 0 and `wr_en_o` = 0, and they leave `flags_o` unchanged.
- R9: An asynchronous active-low reset `rst_ni` clears all four flags to 0 at once.
- R10: `wr_en_o` is 1 for add, subtract and move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation: 0 add, 1 sub, 2 cmp, 3 cmn, 4 move, 5-7 reserved |
| set_flags_i | input | 1 | Request a flag update for add, sub and move |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Computed result |
| wr_en_o | output | 1 | Destination register write-enable |
| flags_o | output | 4 | Flags {N, Z, C, V}, N in bit 3 |

## Verification
The bench builds the block with the default WIDTH of 32. At this width the boundary values can be written directly: 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. That reaches carry out of bit 31, signed overflow on both add and subtract, wrap to zero, and the compare of 0 with -1. The vector sequence is ordered so that held-flag cases follow updates with known, non-zero flag values. This makes a missing update or a missing hold visible. Reset is checked at power-up and again in the middle of the run, before any clock edge.

// File: rtl/as_pkg.sv
package as_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_CMN = 3'd3,
    OP_MOV = 3'd4
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/as_adder.sv
module as_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bop;
  logic [WIDTH:0]   full;

  // subtraction as a + ~b + 1, carry is then inverted borrow
  assign bop    = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, bop} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o  = full[MSB:0];
  assign cout_o = full[WIDTH];
  assign ovf_o  = (a_i[MSB] == bop[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/as_flag_calc.sv
module as_flag_calc #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] sum_i,
  input  logic             cout_i,
  input  logic             ovf_i,
  input  logic [WIDTH-1:0] b_i,
  input  as_pkg::flags_t   cur_i,
  output as_pkg::flags_t   nxt_o,
  output logic             upd_o
);
  import as_pkg::*;
  localparam int MSB = WIDTH - 1;

  always_comb begin
    nxt_o = cur_i;
    upd_o = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        upd_o = set_flags_i;
        nxt_o = '{n: sum_i[MSB], z: (sum_i == '0), c: cout_i, v: ovf_i};
      end
      OP_CMP, OP_CMN: begin
        upd_o = 1'b1;
        nxt_o = '{n: sum_i[MSB], z: (sum_i == '0), c: cout_i, v: ovf_i};
      end
      OP_MOV: begin
        upd_o = set_flags_i;
        nxt_o = '{n: b_i[MSB], z: (b_i == '0), c: cur_i.c, v: cur_i.v};
      end
      default: begin
        upd_o = 1'b0;
        nxt_o = cur_i;
      end
    endcase
  end
endmodule

// File: rtl/as_flag_reg.sv
module as_flag_reg (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           upd_i,
  input  as_pkg::flags_t nxt_i,
  output as_pkg::flags_t flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (upd_i) flags_o <= nxt_i;
  end

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) rst_clear_chk: assert (flags_o == '0);
  end

  // R5
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o));
endmodule

// File: rtl/as_flag_alu.sv
module as_flag_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             set_flags_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o
);
  import as_pkg::*;

  logic [WIDTH-1:0] sum;
  logic             cout, ovf, is_sub, upd;
  flags_t           cur, nxt;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);

  as_adder #(.WIDTH(WIDTH)) u_add (
    .a_i(a_i), .b_i(b_i), .sub_i(is_sub),
    .sum_o(sum), .cout_o(cout), .ovf_o(ovf)
  );

  as_flag_calc #(.WIDTH(WIDTH)) u_calc (
    .op_i(op_i), .set_flags_i(set_flags_i), .sum_i(sum), .cout_i(cout),
    .ovf_i(ovf), .b_i(b_i), .cur_i(cur), .nxt_o(nxt), .upd_o(upd)
  );

  as_flag_reg u_freg (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd), .nxt_i(nxt), .flags_o(cur)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: begin result_o = sum; wr_en_o = 1'b1; end
      OP_CMP, OP_CMN: begin result_o = sum; wr_en_o = 1'b0; end
      OP_MOV:         begin result_o = b_i; wr_en_o = 1'b1; end
      default:        begin result_o = '0;  wr_en_o = 1'b0; end
    endcase
  end

  assign flags_o = cur;

  // R6
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP || op_i == OP_CMN) |-> !wr_en_o);

  // R3
  cmp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |=> (flags_o[2] == ($past(a_i) == $past(b_i))));

  // R2
  cmp_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP) |=> (flags_o[1] == ($past(a_i) >= $past(b_i))));

  // R7
  mov_cv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MOV) |=> $stable(flags_o[1:0]));

  // R8
  rsvd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 3'd4) |=> $stable(flags_o));
endmodule

// File: tb/tb_as_flag_alu.sv
module tb_as_flag_alu;
  localparam int W  = 32;
  localparam int NV = 17;

  typedef struct packed {
    logic [2:0]   op;
    logic         set;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         we;
    logic [3:0]   fl;   // {N,Z,C,V} after the edge
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b1, 4'b0000},
    '{3'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'b0110},
    '{3'd0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'b0110},
    '{3'd0, 1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b1, 4'b1001},
    '{3'd1, 1'b1, 32'd11,        32'd10,        32'd1,         1'b1, 4'b0010},
    '{3'd1, 1'b1, 32'd10,        32'd10,        32'd0,         1'b1, 4'b0110},
    '{3'd1, 1'b1, 32'd9,         32'd10,        32'hFFFF_FFFF, 1'b1, 4'b1000},
    '{3'd1, 1'b1, 32'h8000_0000, 32'd1,         32'h7FFF_FFFF, 1'b1, 4'b0011},
    '{3'd2, 1'b0, 32'd0,         32'hFFFF_FFFF, 32'd1,         1'b0, 4'b0000},
    '{3'd3, 1'b0, 32'd5,         32'hFFFF_FFFB, 32'd0,         1'b0, 4'b0110},
    '{3'd4, 1'b1, 32'd7,         32'h8000_0000, 32'h8000_0000, 1'b1, 4'b1010},
    '{3'd4, 1'b0, 32'd7,         32'd0,         32'd0,         1'b1, 4'b1010},
    '{3'd4, 1'b1, 32'd7,         32'd0,         32'd0,         1'b1, 4'b0110},
    '{3'd2, 1'b1, 32'd10,        32'd9,         32'd1,         1'b0, 4'b0010},
    '{3'd1, 1'b0, 32'd0,         32'd1,         32'hFFFF_FFFF, 1'b1, 4'b0010},
    '{3'd5, 1'b1, 32'd3,         32'd3,         32'd0,         1'b0, 4'b0010},
    '{3'd3, 1'b1, 32'h8000_0000, 32'h8000_0000, 32'd0,         1'b0, 4'b0111}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op = '0;
  logic         set = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] res;
  logic         we;
  logic [3:0]   fl;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  as_flag_alu #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .set_flags_i(set),
    .a_i(a), .b_i(b), .result_o(res), .wr_en_o(we), .flags_o(fl)
  );

  function automatic string flag_tag(logic [2:0] o, logic s);
    case (o)
      3'd0: return s ? "R1 R3 R4" : "R5";
      3'd1: return s ? "R2 R3 R4" : "R5";
      3'd2, 3'd3: return "R6";
      3'd4: return s ? "R7" : "R5";
      default: return "R8";
    endcase
  endfunction

  function automatic string out_tag(logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R10";
      3'd2, 3'd3: return "R6";
      3'd4: return "R7 R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    #25000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9: flags cleared while in reset
    check("R9", "flags in reset", W'(fl), W'(4'b0000));
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op = VECS[i].op; set = VECS[i].set; a = VECS[i].a; b = VECS[i].b;
      #1;
      check(out_tag(op), "result", res, VECS[i].res);
      check(out_tag(op), "wr_en", W'(we), W'(VECS[i].we));
      @(negedge clk);
      check(flag_tag(VECS[i].op, VECS[i].set), "flags", W'(fl), W'(VECS[i].fl));
    end

    // R9: async clear mid-run, before any edge
    op = 3'd3; set = 1'b0; a = 32'hFFFF_FFFF; b = 32'h1;
    @(negedge clk);
    check("R6", "flags cmn wrap", W'(fl), W'(4'b0110));
    #2 rst_n = 1'b0;
    #1 check("R9", "flags async clear", W'(fl), W'(4'b0000));
    @(negedge clk);
    rst_n = 1'b1;
    op = 3'd0; set = 1'b0;
    @(negedge clk);
    check("R5", "flags hold after reset", W'(fl), W'(4'b0000));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule